// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block turns a fast system clock into the bit-level timing of a CAN-style serial bus. A prescaler makes a time quantum from the clock. Each bit is built as one synchronization quantum followed by two programmable phase segments. The sample point lies where the first phase segment ends and the second begins. At that point the block captures the receive line, either once or as a majority vote over three quanta, and presents the result as a registered bit. It also emits one-cycle strobes for every quantum, for the sample point and for the end of each bit.

The block follows the bus phase. When the receive line falls from recessive (1) to dominant (0) outside the synchronization quantum, the current bit is adjusted. An edge in the first segment stretches that segment. An edge in the second segment trims that segment. The adjustment is limited by a programmable jump width. A frame decoder placed downstream consumes the sampled bit and the strobes.

Two configuration bytes set the timing:
- Byte 0 holds the jump width field J in bits 7:6 and the prescaler field P in bits 5:0.
- Byte 1 holds the triple-sample select in bit 7, the second segment field B in bits 6:4 and the first segment field A in bits 3:0.

Top module: `can_bit_timer`

## Requirements
- R1: `tq_tick` pulses high for exactly one clock once every 2*(P+1) clocks, where P = `cfg_t0[5:0]`.
- R2: When no adjustment occurs, a bit lasts 1 + (A+1) + (B+1) quanta, with A = `cfg_t1[3:0]` and B = `cfg_t1[6:4]`. The lengths are read when the first segment starts. `bit_end` pulses in the same cycle as the `tq_tick` that closes the last quantum of the bit.
- R3: `sample_stb` pulses in the same cycle as the `tq_tick` that closes the last quantum of the first segment. It never coincides with `bit_end`.
- R4: With `cfg_t1[7]`=0, `rx_bit` takes the value that `rx_line` had at the clock edge that closed the sampling quantum. `rx_bit` changes only in a `sample_stb` cycle.
- R5: With `cfg_t1[7]`=1, `rx_bit` takes the majority of the line values seen at the three most recent quantum closings, the last of which is the sampling quantum.
- R6: The line is sampled once per quantum, at the clock edge that closes the quantum. A falling edge means that the previous quantum's sample was 1 and the current sample is 0.
- R7: A falling edge seen at quantum index k (counted from 0) of the first segment lengthens that segment by min(k+1, J+1) quanta, where J = `cfg_t0[7:6]`.
- R8: A falling edge seen at quantum index k of the second segment, whose length is L, shortens that segment by min(L-1-k, J+1) quanta.
- R9: At most one adjustment is made per bit. Edges seen in the synchronization quantum cause no adjustment.
- R10: While `rst` is high, all strobes are 0 and `rx_bit` is 1. After reset, the first bit starts with its synchronization quantum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_t0 | input | 8 | Timing byte 0: jump width field [7:6], prescaler [5:0] |
| cfg_t1 | input | 8 | Timing byte 1: triple-sample select [7], second segment [6:4], first segment [3:0] |
| rx_line | input | 1 | Receive line, already synchronous to clk (1 = recessive) |
| tq_tick | output | 1 | One-cycle pulse per quantum boundary |
| sample_stb | output | 1 | One-cycle pulse at the sample point |
| rx_bit | output | 1 | Registered sampled bit value |
| bit_end | output | 1 | One-cycle pulse at the end of each bit |

## Verification
The bench drives the receive line in several ways: held high, toggled at random, and with glitches lasting a single quantum. It uses the smallest prescaler, a large prescaler, the shortest segments and the longest segments. Edges that fall in the first quantum of a segment test the `k+1` growth limit; a design that grows by the raw jump width would produce long bits. Edges that fall in the last quantum of the second segment must produce no trimming; an off-by-one error there would shorten bits by one quantum. Glitches lasting one quantum, when triple sampling is on, expose a design that votes over the wrong window or reads the line only once. Repeated edges within one bit expose a design that resynchronizes more than once per bit.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_ONE  = 2'd1,
    SEG_TWO  = 2'd2
  } seg_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/bt_prescaler.sv
module bt_prescaler #(
  parameter int PSC_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PSC_W-1:0] psc_fld,
  output logic             tq_en
);
  localparam int CNT_W = PSC_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;

  // a quantum spans 2*(P+1) clocks, so the last count is 2P+1
  assign last_cnt = {psc_fld, 1'b1};
  assign tq_en    = (cnt_q >= last_cnt);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (tq_en) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bt_sampler.sv
module bt_sampler (
  input  logic clk,
  input  logic rst,
  input  logic tq_en,
  input  logic rx_line,
  output logic fall_seen,
  output logic voted
);
  import can_bt_pkg::*;

  logic hist1_q, hist2_q;

  assign fall_seen = tq_en && hist1_q && !rx_line;
  assign voted     = vote3(hist2_q, hist1_q, rx_line);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist1_q <= 1'b1;
      hist2_q <= 1'b1;
    end else if (tq_en) begin
      hist1_q <= rx_line;
      hist2_q <= hist1_q;
    end
  end
endmodule

// File: rtl/bt_segmenter.sv
module bt_segmenter #(
  parameter int T1_W = 4,
  parameter int T2_W = 3,
  parameter int J_W  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tq_en,
  input  logic            fall_seen,
  input  logic [T1_W-1:0] t1_fld,
  input  logic [T2_W-1:0] t2_fld,
  input  logic [J_W-1:0]  jw_fld,
  output logic            at_sample,
  output logic            at_end
);
  import can_bt_pkg::*;

  localparam int LEN_W = ((T1_W > T2_W) ? T1_W : T2_W) + 2;

  seg_e             seg_q;
  logic [LEN_W-1:0] qcnt_q, len1_q, len2_q;
  logic             done_q;

  logic             adj;
  logic [LEN_W-1:0] jw, pos1, grow, rem, cut, len1_n, len2_n;

  always_comb begin
    adj    = fall_seen && !done_q;
    jw     = LEN_W'(jw_fld) + 1'b1;
    pos1   = qcnt_q + 1'b1;
    grow   = (pos1 < jw) ? pos1 : jw;
    rem    = len2_q - qcnt_q - 1'b1;
    cut    = (rem < jw) ? rem : jw;
    len1_n = len1_q + ((adj && seg_q == SEG_ONE) ? grow : '0);
    len2_n = len2_q - ((adj && seg_q == SEG_TWO) ? cut : '0);
    at_sample = tq_en && (seg_q == SEG_ONE) && (pos1 >= len1_n);
    at_end    = tq_en && (seg_q == SEG_TWO) && (pos1 >= len2_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q  <= SEG_SYNC;
      qcnt_q <= '0;
      len1_q <= '0;
      len2_q <= '0;
      done_q <= 1'b0;
    end else if (tq_en) begin
      case (seg_q)
        SEG_SYNC: begin
          seg_q  <= SEG_ONE;
          qcnt_q <= '0;
          len1_q <= LEN_W'(t1_fld) + 1'b1;
          len2_q <= LEN_W'(t2_fld) + 1'b1;
          done_q <= 1'b0;
        end
        SEG_ONE: begin
          len1_q <= len1_n;
          if (adj) done_q <= 1'b1;
          if (at_sample) begin
            seg_q  <= SEG_TWO;
            qcnt_q <= '0;
          end else qcnt_q <= pos1;
        end
        SEG_TWO: begin
          len2_q <= len2_n;
          if (adj) done_q <= 1'b1;
          if (at_end) begin
            seg_q  <= SEG_SYNC;
            qcnt_q <= '0;
          end else qcnt_q <= pos1;
        end
        default: seg_q <= SEG_SYNC;
      endcase
    end
  end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int PSC_W = 6,
  parameter int T1_W  = 4,
  parameter int T2_W  = 3,
  parameter int J_W   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] cfg_t0,
  input  logic [7:0] cfg_t1,
  input  logic       rx_line,
  output logic       tq_tick,
  output logic       sample_stb,
  output logic       rx_bit,
  output logic       bit_end
);
  localparam int MODE_BIT = T1_W + T2_W;

  logic tq_en, fall_seen, voted, at_sample, at_end;

  bt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .psc_fld(cfg_t0[PSC_W-1:0]), .tq_en(tq_en)
  );

  bt_sampler u_smp (
    .clk(clk), .rst(rst), .tq_en(tq_en), .rx_line(rx_line),
    .fall_seen(fall_seen), .voted(voted)
  );

  bt_segmenter #(.T1_W(T1_W), .T2_W(T2_W), .J_W(J_W)) u_seg (
    .clk(clk), .rst(rst), .tq_en(tq_en), .fall_seen(fall_seen),
    .t1_fld(cfg_t1[T1_W-1:0]), .t2_fld(cfg_t1[MODE_BIT-1:T1_W]),
    .jw_fld(cfg_t0[PSC_W+J_W-1:PSC_W]),
    .at_sample(at_sample), .at_end(at_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tq_tick    <= 1'b0;
      sample_stb <= 1'b0;
      bit_end    <= 1'b0;
      rx_bit     <= 1'b1;
    end else begin
      tq_tick    <= tq_en;
      sample_stb <= at_sample;
      bit_end    <= at_end;
      if (at_sample) rx_bit <= cfg_t1[MODE_BIT] ? voted : rx_line;
    end
  end
endmodule

// File: rtl/can_bit_timer_checker.sv
module can_bit_timer_checker (
  input logic       clk,
  input logic       rst,
  input logic [7:0] cfg_t1,
  input logic       rx_line,
  input logic       tq_tick,
  input logic       sample_stb,
  input logic       rx_bit,
  input logic       bit_end
);
  p_tick_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    tq_tick |=> !tq_tick);

  p_end_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    bit_end |-> tq_tick);

  p_smp_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> tq_tick);

  p_smp_not_end_r3: assert property (@(posedge clk) disable iff (rst)
    !(sample_stb && bit_end));

  p_bit_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !sample_stb |-> $stable(rx_bit));

  p_single_value_r4: assert property (@(posedge clk) disable iff (rst)
    (sample_stb && !$past(cfg_t1[7])) |-> (rx_bit == $past(rx_line)));
endmodule

bind can_bit_timer can_bit_timer_checker u_chk (
  .clk(clk), .rst(rst), .cfg_t1(cfg_t1), .rx_line(rx_line),
  .tq_tick(tq_tick), .sample_stb(sample_stb), .rx_bit(rx_bit), .bit_end(bit_end)
);

// File: tb/can_bit_timer_bench.sv
module can_bit_timer_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] cfg_t0 = 8'h00;
  logic [7:0] cfg_t1 = 8'h00;
  logic rx_line = 1'b1;
  logic tq_tick, sample_stb, rx_bit, bit_end;

  always #5 clk = ~clk;

  can_bit_timer u_can_bit_timer (
    .clk(clk), .rst(rst), .cfg_t0(cfg_t0), .cfg_t1(cfg_t1), .rx_line(rx_line),
    .tq_tick(tq_tick), .sample_stb(sample_stb), .rx_bit(rx_bit), .bit_end(bit_end)
  );

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  int  pc, ph, k, l1, l2, jw, lim, cyc, last_end;
  bit  done, prev, h2, s, fall;
  bit  e_tick, e_smp, e_bit, e_end;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      pc = 0; ph = 0; k = 0; l1 = 0; l2 = 0; done = 0;
      prev = 1; h2 = 1;
      e_tick = 0; e_smp = 0; e_end = 0; e_bit = 1;
    end else begin
      lim = 2 * (int'(cfg_t0[5:0]) + 1);
      jw  = int'(cfg_t0[7:6]) + 1;
      e_tick = 0; e_smp = 0; e_end = 0;
      if (pc == lim - 1) begin
        pc = 0;
        e_tick = 1;
        s = rx_line;
        fall = prev && !s;
        if (ph == 0) begin
          ph = 1; k = 0; done = 0;
          l1 = int'(cfg_t1[3:0]) + 1;
          l2 = int'(cfg_t1[6:4]) + 1;
        end else if (ph == 1) begin
          if (fall && !done) begin
            l1 += (k + 1 < jw) ? k + 1 : jw;
            done = 1;
          end
          if (k + 1 >= l1) begin
            ph = 2; k = 0; e_smp = 1;
            if (cfg_t1[7]) e_bit = (int'(h2) + int'(prev) + int'(s)) >= 2;
            else e_bit = s;
          end else k++;
        end else begin
          if (fall && !done) begin
            l2 -= (l2 - 1 - k < jw) ? l2 - 1 - k : jw;
            done = 1;
          end
          if (k + 1 >= l2) begin
            ph = 0; k = 0; e_end = 1;
          end else k++;
        end
        h2 = prev;
        prev = s;
      end else pc++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(tq_tick == e_tick, "R1 tq_tick", tq_tick, e_tick);
    chk(sample_stb == e_smp, "R3/R7/R8/R9 sample_stb", sample_stb, e_smp);
    chk(bit_end == e_end, "R2/R7/R8/R9 bit_end", bit_end, e_end);
    chk(rx_bit == e_bit, "R4/R5/R6 rx_bit", rx_bit, e_bit);
  endtask

  // mode 0: line held high, 1: random level changes, 2: one-quantum glitches
  task automatic run_cfg(input logic [7:0] c0, input logic [7:0] c1,
                         input int ncyc, input int mode);
    int per, hold;
    @(negedge clk);
    rst = 1'b1; cfg_t0 = c0; cfg_t1 = c1; rx_line = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset values
    chk(tq_tick == 0 && sample_stb == 0 && bit_end == 0, "R10 strobes in reset",
        int'({tq_tick, sample_stb, bit_end}), 0);
    chk(rx_bit == 1, "R10 rx_bit in reset", rx_bit, 1);
    rst = 1'b0;
    per = 2 * (int'(c0[5:0]) + 1);
    last_end = -1;
    hold = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      compare_all();
      if (mode == 0 && bit_end) begin
        // R2: nominal bit period with no edges
        if (last_end >= 0)
          chk(cyc - last_end == per * (3 + int'(c1[3:0]) + int'(c1[6:4])),
              "R2 bit period", cyc - last_end, per * (3 + int'(c1[3:0]) + int'(c1[6:4])));
        last_end = cyc;
      end
      if (mode == 1) begin
        if ($urandom_range(0, 7 * per) == 0) rx_line = ~rx_line;
      end else if (mode == 2) begin
        if (hold > 0) begin
          hold--;
          if (hold == 0) rx_line = ~rx_line;
        end else if ($urandom_range(0, 5 * per) == 0) begin
          rx_line = ~rx_line;
          hold = per;
        end
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc = 0;
    run_cfg(8'h00, 8'h23, 600, 0);   // fastest quantum, R2 period
    run_cfg(8'h45, 8'h7F, 3000, 0);  // large prescaler, longest segments
    run_cfg(8'h00, 8'h00, 3000, 1);  // shortest segments, R7/R8 limits
    run_cfg(8'hC1, 8'h47, 8000, 1);  // J=3, R7/R8/R9
    run_cfg(8'h40, 8'h35, 8000, 1);  // J=1
    run_cfg(8'h01, 8'hB6, 8000, 2);  // triple sampling, glitches, R5
    run_cfg(8'h82, 8'h24, 8000, 2);  // single sampling, glitches, R4/R6
    run_cfg(8'hC0, 8'hFF, 8000, 1);  // triple, long segments
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule